// File: doc/BRIEF.md
# Eleven-Bit Minifloat Adder

This block adds or subtracts two small floating-point numbers held in an 11-bit word. Bit 10 is the sign, bits 9:6 are a biased exponent (bias 7), and bits 5:0 are the fraction. Every nonzero finite value has a hidden leading one. The block does not support subnormals. The operand with the smaller magnitude is shifted right until it matches the exponent of the larger one. The significands are then added or subtracted on a path that keeps three extra low bits (guard, round, sticky). The raw result is renormalised and then rounded to nearest, with ties going to even.

The datapath is combinational from the operand ports to a single output register stage. Each operand pair therefore produces its result and its three flags on the next rising clock edge. Special encodings take a separate path that bypasses the arithmetic: zero, infinity and NaN. Results that fall outside the normal range are clamped, and a flag reports each clamp.

Top module: `minifloat_adder`

## Requirements
- R1: The word layout is bit 10 = sign, bits 9:6 = exponent with bias 7, and bits 5:0 = fraction. A word with exponent 1..14 is worth (1 + fraction/64) x 2^(exponent-7). A word with exponent 0 is read as zero whatever its fraction holds.
- R2: Outputs are registered. The result for operands applied before a rising edge appears after that edge. A synchronous active-high reset clears the result and all flags to 0.
- R3: For finite operands, the block computes a + b when `op_sub` = 0 and a - b when `op_sub` = 1. The smaller-magnitude operand is aligned to the larger exponent.
- R4: The exact sum is rounded to 7 significant bits, nearest first, with exact ties going to the value whose fraction LSB is 0.
- R5: When rounding carries out of the significand, the exponent is raised by one and the fraction becomes 0.
- R6: A rounded result exponent of 15 or more gives a signed infinity (exponent 1111, fraction 0: 0x3C0 positive, 0x7C0 negative) and sets `ovf_o`.
- R7: A nonzero rounded result below 2^-6 is flushed to zero with the sign of the exact result, and `unf_o` is set.
- R8: An exact zero result gives +0 (0x000) with no flag. The exception is when both operands are zero and both effective signs are negative, which gives 0x400.
- R9: Any NaN operand (exponent 1111, fraction nonzero) gives the quiet NaN 0x3E0 (sign 0, exponent 1111, fraction 100000) and sets `inv_o`.
- R10: Infinity minus infinity (effective signs differ) gives 0x3E0 and sets `inv_o`. Infinity combined with any non-NaN value gives the infinity with its effective sign and no flag.
- R11: At most one of `ovf_o`, `unf_o`, `inv_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 11 | First operand |
| op_b | input | 11 | Second operand |
| op_sub | input | 1 | 1 = subtract op_b from op_a |
| sum_o | output | 11 | Registered result word |
| ovf_o | output | 1 | Overflow flag, result is infinity |
| unf_o | output | 1 | Underflow flag, result flushed to zero |
| inv_o | output | 1 | Invalid flag, result is quiet NaN |

## Verification
Every result and flag is due exactly one rising edge after its operands are applied, because the only register on the path is the output stage. The bench drives operands on a falling edge and waits for the next falling edge. There it samples the result half a period after the edge that captured it, so the value read is never the one being updated. Directed cases cover ties, rounding carries, overflow, underflow, cancellation and special encodings. A real-number reference model that rounds the exact sum supplies the expected values for several thousand random operand pairs.

// File: rtl/mfadd_pkg.sv
package mfadd_pkg;
  typedef enum logic [1:0] {K_ZERO, K_NORM, K_INF, K_NAN} kind_e;
endpackage

// File: rtl/mf_unpack.sv
module mf_unpack
  import mfadd_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 6
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  flip,
  output logic                  sgn,
  output logic [EXP_W-1:0]      ex,
  output logic [FRAC_W:0]       sig,
  output kind_e                 kind
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [FRAC_W-1:0] frac;

  assign frac = word[FRAC_W-1:0];
  assign ex   = word[W-2:FRAC_W];
  assign sgn  = word[W-1] ^ flip;

  always_comb begin
    if (&ex) begin
      kind = (frac == '0) ? K_INF : K_NAN;
      sig  = '0;
    end else if (ex == '0) begin
      kind = K_ZERO;
      sig  = '0;
    end else begin
      kind = K_NORM;
      sig  = {1'b1, frac};
    end
  end
endmodule

// File: rtl/mf_align_add.sv
module mf_align_add #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 6,
  parameter int XB     = 3
) (
  input  logic                    sa,
  input  logic [EXP_W-1:0]        ea,
  input  logic [FRAC_W:0]         ma,
  input  logic                    sb,
  input  logic [EXP_W-1:0]        eb,
  input  logic [FRAC_W:0]         mb,
  output logic [FRAC_W+XB+1:0]    raw,
  output logic [EXP_W-1:0]        exp_big,
  output logic                    sgn
);
  localparam int EXT_W = FRAC_W + 1 + XB;

  logic                   a_big;
  logic [FRAC_W:0]        m_big, m_sml;
  logic [EXP_W-1:0]       e_sml, diff;
  logic [2*EXT_W-1:0]     wide;
  logic [EXT_W-1:0]       aligned, ext_big;
  logic                   sticky;

  assign a_big   = {ea, ma} >= {eb, mb};
  assign m_big   = a_big ? ma : mb;
  assign m_sml   = a_big ? mb : ma;
  assign exp_big = a_big ? ea : eb;
  assign e_sml   = a_big ? eb : ea;
  assign sgn     = a_big ? sa : sb;
  assign diff    = exp_big - e_sml;

  assign ext_big = {m_big, {XB{1'b0}}};
  assign wide    = {m_sml, {XB{1'b0}}, {EXT_W{1'b0}}} >> diff;
  assign sticky  = |wide[EXT_W-1:0];
  assign aligned = {wide[2*EXT_W-1:EXT_W+1], wide[EXT_W] | sticky};

  always_comb begin
    if (sa ^ sb) raw = {1'b0, ext_big} - {1'b0, aligned};
    else         raw = {1'b0, ext_big} + {1'b0, aligned};
  end
endmodule

// File: rtl/mf_norm_round.sv
module mf_norm_round #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 6,
  parameter int XB     = 3
) (
  input  logic [FRAC_W+XB+1:0]    raw,
  input  logic [EXP_W-1:0]        exp_big,
  input  logic                    sgn,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    ovf,
  output logic                    unf,
  output logic                    is_zero
);
  localparam int EXT_W = FRAC_W + 1 + XB;
  localparam int LZW   = $clog2(EXT_W + 1);
  localparam int SEW   = EXP_W + LZW + 1;
  localparam logic signed [SEW-1:0] EMAX_S = SEW'(2**EXP_W - 1);

  logic [LZW-1:0]          lz;
  logic [EXT_W-1:0]        norm;
  logic                    lsb, grd, rest, up;
  logic [FRAC_W+1:0]       mr;
  logic [FRAC_W-1:0]       frac;
  logic signed [SEW-1:0]   e_pre, e_fin;

  always_comb begin
    lz = LZW'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (raw[i]) lz = LZW'(EXT_W - 1 - i);
  end

  always_comb begin
    if (raw[EXT_W]) norm = {raw[EXT_W:2], raw[1] | raw[0]};
    else            norm = raw[EXT_W-1:0] << lz;
  end

  assign e_pre = SEW'(exp_big) + SEW'(raw[EXT_W]) - SEW'(raw[EXT_W] ? '0 : lz);

  assign lsb  = norm[XB];
  assign grd  = norm[XB-1];
  assign rest = |norm[XB-2:0];
  assign up   = grd & (rest | lsb);
  assign mr   = {1'b0, norm[EXT_W-1:XB]} + (FRAC_W+2)'(up);

  assign frac  = mr[FRAC_W+1] ? mr[FRAC_W:1] : mr[FRAC_W-1:0];
  assign e_fin = e_pre + SEW'(mr[FRAC_W+1]);

  assign is_zero = (raw == '0);
  assign ovf     = !is_zero && (e_fin >= EMAX_S);
  assign unf     = !is_zero && (e_fin[SEW-1] || e_fin == '0);

  always_comb begin
    if (is_zero)  word = '0;
    else if (ovf) word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf) word = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    else          word = {sgn, e_fin[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder
  import mfadd_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 6,
  parameter int XB     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic                    op_sub,
  output logic [EXP_W+FRAC_W:0]   sum_o,
  output logic                    ovf_o,
  output logic                    unf_o,
  output logic                    inv_o
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int EXT_W = FRAC_W + 1 + XB;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic               s_a, s_b;
  logic [EXP_W-1:0]   e_a, e_b, e_big;
  logic [FRAC_W:0]    m_a, m_b;
  kind_e              k_a, k_b;
  logic [EXT_W:0]     raw;
  logic               s_big;
  logic [W-1:0]       arith_w, nxt_w;
  logic               a_ovf, a_unf, a_zero, nxt_ovf, nxt_unf, nxt_inv;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    if (g == 0) begin : g_a
      mf_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
        .word(op_a), .flip(1'b0), .sgn(s_a), .ex(e_a), .sig(m_a), .kind(k_a));
    end else begin : g_b
      mf_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
        .word(op_b), .flip(op_sub), .sgn(s_b), .ex(e_b), .sig(m_b), .kind(k_b));
    end
  end

  mf_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XB(XB)) u_add (
    .sa(s_a), .ea(e_a), .ma(m_a), .sb(s_b), .eb(e_b), .mb(m_b),
    .raw(raw), .exp_big(e_big), .sgn(s_big));

  mf_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XB(XB)) u_nr (
    .raw(raw), .exp_big(e_big), .sgn(s_big),
    .word(arith_w), .ovf(a_ovf), .unf(a_unf), .is_zero(a_zero));

  always_comb begin
    nxt_w   = arith_w;
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    nxt_inv = 1'b0;
    if (k_a == K_NAN || k_b == K_NAN) begin
      nxt_w   = QNAN;
      nxt_inv = 1'b1;
    end else if (k_a == K_INF && k_b == K_INF && s_a != s_b) begin
      nxt_w   = QNAN;
      nxt_inv = 1'b1;
    end else if (k_a == K_INF) begin
      nxt_w = {s_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (k_b == K_INF) begin
      nxt_w = {s_b, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (k_a == K_ZERO && k_b == K_ZERO) begin
      nxt_w = {s_a & s_b, {(W-1){1'b0}}};
    end else if (!a_zero) begin
      nxt_ovf = a_ovf;
      nxt_unf = a_unf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      inv_o <= 1'b0;
    end else begin
      sum_o <= nxt_w;
      ovf_o <= nxt_ovf;
      unf_o <= nxt_unf;
      inv_o <= nxt_inv;
    end
  end

  // R6
  ovf_is_inf_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (&sum_o[W-2:FRAC_W]) && (sum_o[FRAC_W-1:0] == '0));

  // R7
  unf_is_zero_chk: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (sum_o[W-2:0] == '0));

  // R9
  nan_in_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (k_a == K_NAN || k_b == K_NAN) |=> inv_o && (sum_o == QNAN));

  // R10
  inf_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (k_a == K_INF && k_b == K_INF && s_a != s_b) |=> inv_o);

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o, inv_o}));
endmodule

// File: tb/minifloat_adder_test.sv
module minifloat_adder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic [10:0] sum_o;
  logic        ovf_o, unf_o, inv_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  minifloat_adder uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o), .inv_o(inv_o));

  function automatic real p2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real val(logic [10:0] x, logic s);
    real m;
    if (x[9:6] == 4'd0) return 0.0;
    m = (1.0 + real'(x[5:0]) / 64.0) * p2(int'(x[9:6]) - 7);
    return s ? -m : m;
  endfunction

  // {inv, ovf, unf, result}
  function automatic logic [13:0] model(logic [10:0] a, logic [10:0] b, logic sub);
    logic sa, sb, s;
    logic an, bn, ai, bi;
    real v, m, sc, rem;
    int e, fl, be;
    sa = a[10]; sb = b[10] ^ sub;
    an = (a[9:6] == 4'hF) && (a[5:0] != 0); bn = (b[9:6] == 4'hF) && (b[5:0] != 0);
    ai = (a[9:6] == 4'hF) && (a[5:0] == 0); bi = (b[9:6] == 4'hF) && (b[5:0] == 0);
    if (an || bn) return {3'b100, 11'h3E0};
    if (ai && bi) return (sa != sb) ? {3'b100, 11'h3E0} : {3'b000, sa, 10'h3C0};
    if (ai) return {3'b000, sa, 10'h3C0};
    if (bi) return {3'b000, sb, 10'h3C0};
    v = val(a, sa) + val(b, sb);
    if (v == 0.0) begin
      if (a[9:6] == 0 && b[9:6] == 0) return {3'b000, sa & sb, 10'h000};
      return 14'h0;
    end
    s = (v < 0.0); m = s ? -v : v; e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    sc = m * 64.0; fl = $rtoi(sc); rem = sc - real'(fl);
    if (rem > 0.5 || (rem == 0.5 && (fl % 2) == 1)) fl++;
    if (fl == 128) begin fl = 64; e++; end
    be = e + 7;
    if (be >= 15) return {3'b010, s, 10'h3C0};
    if (be <= 0)  return {3'b001, s, 10'h000};
    return {3'b000, s, be[3:0], 6'(fl - 64)};
  endfunction

  task automatic check(string req, logic [13:0] act, logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got flags(i,o,u)=%b res=%h, expected flags=%b res=%h",
               req, act[13:11], act[10:0], exp[13:11], exp[10:0]);
    end
  endtask

  // Result is due at the edge after the drive; sampled one falling edge later.
  task automatic apply(string req, logic [10:0] a, logic [10:0] b, logic sub, logic [13:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub;
    @(negedge clk);
    check(req, {inv_o, ovf_o, unf_o, sum_o}, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 reset", {inv_o, ovf_o, unf_o, sum_o}, 14'h0);
    rst = 1'b0;
  endtask

  task automatic t_basic;
    apply("R3 1+1", 11'h1C0, 11'h1C0, 1'b0, {3'b000, 11'h200});
    apply("R3 2-1", 11'h200, 11'h1C0, 1'b1, {3'b000, 11'h1C0});
    apply("R3 1-2", 11'h1C0, 11'h200, 1'b1, {3'b000, 11'h5C0});
    apply("R1 exp0 is zero", 11'h1C0, 11'h005, 1'b0, {3'b000, 11'h1C0});
  endtask

  task automatic t_round;
    apply("R4 tie even down", 11'h200, 11'h040, 1'b0, {3'b000, 11'h200});
    apply("R4 tie odd up", 11'h201, 11'h040, 1'b0, {3'b000, 11'h202});
    apply("R5 carry renorm", 11'h1FF, 11'h040, 1'b0, model(11'h1FF, 11'h040, 1'b0));
    apply("R5 carry value", 11'h1FF, 11'h080, 1'b0, {3'b000, 11'h200});
  endtask

  task automatic t_range;
    apply("R6 overflow pos", 11'h3BF, 11'h3BF, 1'b0, {3'b010, 11'h3C0});
    apply("R6 overflow neg", 11'h7BF, 11'h3BF, 1'b1, {3'b010, 11'h7C0});
    apply("R7 underflow", 11'h041, 11'h040, 1'b1, {3'b001, 11'h000});
    apply("R7 underflow neg", 11'h040, 11'h041, 1'b1, {3'b001, 11'h400});
    apply("R8 cancel", 11'h5A3, 11'h5A3, 1'b1, {3'b000, 11'h000});
    apply("R8 neg zeros", 11'h400, 11'h000, 1'b1, {3'b000, 11'h400});
  endtask

  task automatic t_special;
    apply("R9 nan a", 11'h3C1, 11'h1C0, 1'b0, {3'b100, 11'h3E0});
    apply("R9 nan b", 11'h1C0, 11'h7FF, 1'b1, {3'b100, 11'h3E0});
    apply("R10 inf-inf", 11'h3C0, 11'h3C0, 1'b1, {3'b100, 11'h3E0});
    apply("R10 inf+inf", 11'h7C0, 11'h7C0, 1'b0, {3'b000, 11'h7C0});
    apply("R10 1-inf", 11'h1C0, 11'h3C0, 1'b1, {3'b000, 11'h7C0});
  endtask

  task automatic t_random;
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] a, b;
      logic s;
      a = 11'($urandom); b = 11'($urandom); s = 1'($urandom);
      if (i % 2 == 0) b[9:6] = a[9:6] ^ 4'($urandom_range(0, 1));
      apply("R3/R4/R11 random", a, b, s, model(a, b, s));
    end
  endtask

  task automatic t_reset_again;
    apply("R6 before reset", 11'h3BF, 11'h3BF, 1'b0, {3'b010, 11'h3C0});
    rst = 1'b1;
    @(negedge clk);
    check("R2 sync reset", {inv_o, ovf_o, unf_o, sum_o}, 14'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_round();
    t_range();
    t_special();
    t_random();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule